// File: doc/BRIEF.md
# DMA Interrupt Coalescing Unit

This block cuts the interrupt rate of a DMA channel. It sees a single-cycle pulse for every finished frame and keeps two pieces of state: a frame counter that counts down from a programmable threshold, and an idle delay timer that restarts from a programmable delay each time a frame finishes. When the counter runs out, the block pulses a request to set the completion interrupt flag. When the timer runs out, it pulses a request to set the delay interrupt flag. This bounds how long a short burst of frames can sit without raising an interrupt.

The surrounding channel logic owns the control register. It passes the threshold field (control bits 23:16) and the delay field (control bits 31:24) to this block, and pulses a reload strobe on every write to that register. The timer advances only on a tick-enable pulse, which sets the timer resolution. Interrupt flag storage and masking sit outside this block. The current counter and timer values are brought out so the status register can report them.

Top module: `irq_coalesce`

## Requirements
- R1: After reset the frame counter reads 1, the timer reads 0, and both set pulses are low.
- R2: A frame-done pulse that does not take the counter to zero decrements `cnt_val` by one, visible on the cycle after the pulse. With no frame-done and no reload, `cnt_val` holds its value.
- R3: A frame-done pulse seen while `cnt_val` is 1 drives `ioc_set` high for exactly the next cycle and loads `cnt_val` with `cfg_thresh`.
- R4: A threshold of 0 behaves as 256: the first decrement wraps to 255, and the completion pulse comes on the 256th frame after the load.
- R5: A frame-done pulse with a nonzero `cfg_delay` restarts the timer, so `tmr_val` equals `cfg_delay` on the next cycle, even if the timer was already running. A frame-done pulse with `cfg_delay` equal to 0 leaves the timer untouched.
- R6: While the timer is running, each `tick_en` pulse decrements `tmr_val`. The tick that takes it to 0 drives `dly_set` high for exactly one cycle and stops the timer.
- R7: Timer expiry loads the frame counter with `cfg_thresh` on the same edge that raises `dly_set`.
- R8: A `ctrl_wr` pulse loads the counter with `cfg_thresh`. A reload (from `ctrl_wr` or from expiry) overrides a decrement in the same cycle, but a completion pulse caused by that same frame still fires.
- R9: `tick_en` pulses while the timer is stopped leave `tmr_val` unchanged and raise no `dly_set`.
- R10: A frame-done pulse that restarts the timer takes priority over an expiry in the same cycle: `dly_set` stays low and the timer reloads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| frame_done | input | 1 | One-cycle pulse per completed frame |
| cfg_thresh | input | 8 | Frame threshold (control bits 23:16) |
| cfg_delay | input | 8 | Delay timer start value (control bits 31:24) |
| ctrl_wr | input | 1 | Pulse on every control register write; reloads the counter |
| tick_en | input | 1 | Timer tick enable |
| ioc_set | output | 1 | One-cycle pulse that sets the completion interrupt flag |
| dly_set | output | 1 | One-cycle pulse that sets the delay interrupt flag |
| cnt_val | output | 8 | Current frame counter value |
| tmr_val | output | 8 | Current delay timer value |

## Verification
Both counters appear directly on `cnt_val` and `tmr_val`, so a wrong decrement, a missed reload or a wrong priority shows up on the port one cycle after the event that caused it. A timer that fails to stop, or one that stops too early, shows up either as a `tmr_val` that keeps moving under idle ticks or as a `dly_set` pulse that is missing or repeated. A wrong counter state can also stay hidden until the next completion; it then appears as an `ioc_set` pulse on the wrong frame. This is why the bench compares every output on every cycle against its model, through long frame runs, threshold 0, and collisions between the reload, frame and tick inputs.

// File: rtl/irq_coalesce_pkg.sv
package irq_coalesce_pkg;
  localparam int DEF_CNT_W      = 8;
  localparam int DEF_TMR_W      = 8;
  localparam int DEF_RST_THRESH = 1;
  localparam int DEF_SYNC_STG   = 2;

  // Events that steer the frame counter in one cycle
  typedef struct packed {
    logic done;
    logic reload;
  } cnt_evt_t;
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  generate
    if (STAGES <= 1) begin : g_single
      logic sr_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q <= 1'b0;
        else        sr_q <= 1'b1;
      end
      assign rst_n_sync = sr_q;
    end else begin : g_chain
      logic [STAGES-1:0] sr_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q <= '0;
        else        sr_q <= {sr_q[STAGES-2:0], 1'b1};
      end
      assign rst_n_sync = sr_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/irq_frame_counter.sv
module irq_frame_counter
  import irq_coalesce_pkg::*;
#(
  parameter int CNT_W   = DEF_CNT_W,
  parameter int RST_VAL = DEF_RST_THRESH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  cnt_evt_t         evt,
  input  logic [CNT_W-1:0] thresh,
  output logic [CNT_W-1:0] cnt,
  output logic             hit
);
  localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);
  localparam logic [CNT_W-1:0] RST_V = CNT_W'(RST_VAL);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             hit_q, hit_d;
  logic             cnt_en;

  always_comb begin
    cnt_d = cnt_q;
    hit_d = 1'b0;
    if (evt.done) begin
      if (cnt_q == ONE) begin
        hit_d = 1'b1;
        cnt_d = thresh;
      end else begin
        cnt_d = cnt_q - ONE;   // 0 wraps to all ones: threshold 0 acts as 2**CNT_W
      end
    end
    if (evt.reload) cnt_d = thresh;
  end

  assign cnt_en = evt.done | evt.reload;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= RST_V;
      hit_q <= 1'b0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      hit_q <= hit_d;
    end
  end

  assign cnt = cnt_q;
  assign hit = hit_q;

  AST_HIT_NEEDS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    hit_q |-> $past(evt.done)); // R3
  AST_CNT_HOLDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!evt.done && !evt.reload) |=> $stable(cnt_q)); // R2
  AST_RELOAD_LOADS_THRESH: assert property (@(posedge clk) disable iff (!rst_n)
    evt.reload |=> (cnt_q == $past(thresh))); // R8
endmodule

// File: rtl/irq_delay_timer.sv
module irq_delay_timer
  import irq_coalesce_pkg::*;
#(
  parameter int TMR_W = DEF_TMR_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_done,
  input  logic [TMR_W-1:0] delay,
  input  logic             tick,
  output logic [TMR_W-1:0] tmr,
  output logic             expire,
  output logic             fire
);
  localparam logic [TMR_W-1:0] ONE = TMR_W'(1);

  logic [TMR_W-1:0] tmr_q, tmr_d;
  logic             run_q, run_d;
  logic             fire_q;
  logic             restart, step, tmr_en;

  assign restart = frame_done && (delay != '0);
  assign step    = run_q && tick;
  assign expire  = !restart && step && (tmr_q == ONE);
  assign tmr_en  = restart | step;

  always_comb begin
    tmr_d = tmr_q;
    run_d = run_q;
    if (restart) begin
      tmr_d = delay;
      run_d = 1'b1;
    end else if (step) begin
      tmr_d = tmr_q - ONE;
      if (tmr_q == ONE) run_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_q  <= '0;
      run_q  <= 1'b0;
      fire_q <= 1'b0;
    end else begin
      if (tmr_en) begin
        tmr_q <= tmr_d;
        run_q <= run_d;
      end
      fire_q <= expire;
    end
  end

  assign tmr  = tmr_q;
  assign fire = fire_q;

  AST_FIRE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    fire_q |=> !fire_q); // R6
  AST_FIRE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    fire_q |-> (tmr_q == '0)); // R6
  AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !frame_done) |=> $stable(tmr_q)); // R9
  AST_RESTART_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && delay != '0) |=> (tmr_q == $past(delay))); // R5
endmodule

// File: rtl/irq_coalesce.sv
module irq_coalesce
  import irq_coalesce_pkg::*;
#(
  parameter int CNT_W      = DEF_CNT_W,
  parameter int TMR_W      = DEF_TMR_W,
  parameter int RST_THRESH = DEF_RST_THRESH,
  parameter int SYNC_STG   = DEF_SYNC_STG
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_done,
  input  logic [CNT_W-1:0] cfg_thresh,
  input  logic [TMR_W-1:0] cfg_delay,
  input  logic             ctrl_wr,
  input  logic             tick_en,
  output logic             ioc_set,
  output logic             dly_set,
  output logic [CNT_W-1:0] cnt_val,
  output logic [TMR_W-1:0] tmr_val
);
  logic     rst_n_i;
  logic     tmr_expire;
  cnt_evt_t cnt_evt;

  irq_rst_sync #(.STAGES(SYNC_STG)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  irq_delay_timer #(.TMR_W(TMR_W)) u_tmr (
    .clk        (clk),
    .rst_n      (rst_n_i),
    .frame_done (frame_done),
    .delay      (cfg_delay),
    .tick       (tick_en),
    .tmr        (tmr_val),
    .expire     (tmr_expire),
    .fire       (dly_set)
  );

  assign cnt_evt.done   = frame_done;
  assign cnt_evt.reload = ctrl_wr | tmr_expire;

  irq_frame_counter #(.CNT_W(CNT_W), .RST_VAL(RST_THRESH)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n_i),
    .evt    (cnt_evt),
    .thresh (cfg_thresh),
    .cnt    (cnt_val),
    .hit    (ioc_set)
  );

  AST_EXPIRY_RELOADS_CNT: assert property (@(posedge clk) disable iff (!rst_n_i)
    dly_set |-> (cnt_val == $past(cfg_thresh))); // R7
  AST_RESTART_BLOCKS_FIRE: assert property (@(posedge clk) disable iff (!rst_n_i)
    (frame_done && cfg_delay != '0) |=> !dly_set); // R10
endmodule

// File: tb/irq_coalesce_test.sv
module irq_coalesce_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_done = 1'b0;
  logic [7:0] cfg_thresh = 8'd0;
  logic [7:0] cfg_delay = 8'd0;
  logic       ctrl_wr = 1'b0;
  logic       tick_en = 1'b0;
  logic       ioc_set, dly_set;
  logic [7:0] cnt_val, tmr_val;

  int n_cmp = 0;
  int n_bad = 0;
  int cycles = 0;
  string req = "R1";

  // reference model state
  int m_cnt = 1, m_tmr = 0, m_run = 0, m_ioc = 0, m_dly = 0, m_rstc = 0;

  irq_coalesce uut (
    .clk(clk), .rst_n(rst_n), .frame_done(frame_done), .cfg_thresh(cfg_thresh),
    .cfg_delay(cfg_delay), .ctrl_wr(ctrl_wr), .tick_en(tick_en),
    .ioc_set(ioc_set), .dly_set(dly_set), .cnt_val(cnt_val), .tmr_val(tmr_val)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    int th, dl, c, t, rs, ex, io;
    cycles++;
    if (!rst_n) m_rstc = 0;
    if (m_rstc < 2) begin
      m_cnt = 1; m_tmr = 0; m_run = 0; m_ioc = 0; m_dly = 0;
      if (rst_n) m_rstc++;
    end else begin
      th = cfg_thresh; dl = cfg_delay;
      rs = (frame_done && dl != 0) ? 1 : 0;
      ex = (!rs && m_run != 0 && tick_en && m_tmr == 1) ? 1 : 0;
      c = m_cnt; io = 0;
      if (frame_done) begin
        c = (m_cnt + 255) % 256;
        if (c == 0) begin io = 1; c = th; end
      end
      if (ctrl_wr || ex) c = th;
      t = m_tmr;
      if (rs) begin t = dl; m_run = 1; end
      else if (m_run != 0 && tick_en) begin
        t = m_tmr - 1;
        if (t == 0) m_run = 0;
      end
      m_cnt = c; m_tmr = t; m_ioc = io; m_dly = ex;
    end
  end

  task automatic chk(input string what, input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s (%s) at cycle %0d: actual %0d expected %0d", tag, what, req, cycles, act, exp);
    end
  endtask

  always @(negedge clk) begin
    chk("cnt_val", "R2", cnt_val, m_cnt);
    chk("tmr_val", "R5", tmr_val, m_tmr);
    chk("ioc_set", "R3", ioc_set, m_ioc);
    chk("dly_set", "R6", dly_set, m_dly);
  end

  task automatic cyc(input bit fd, input bit cw, input bit te);
    @(negedge clk);
    frame_done = fd; ctrl_wr = cw; tick_en = te;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0);
  endtask

  task automatic finish_run;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #150000;
    n_bad++;
    $display("FAIL watchdog: run hung, actual running expected done");
    finish_run();
  end

  initial begin
    logic [15:0] lf;
    req = "R1";                       // reset values
    idle(4);
    rst_n = 1'b1;
    idle(4);

    req = "R2 R3";                    // threshold 3, spaced frames
    cfg_thresh = 8'd3; cfg_delay = 8'd0;
    cyc(0, 1, 0);
    for (int i = 0; i < 7; i++) begin cyc(1, 0, 0); cyc(0, 0, 0); end
    req = "R3";                       // back-to-back frames
    for (int i = 0; i < 8; i++) cyc(1, 0, 0);
    idle(2);

    req = "R4";                       // threshold 0 means 256
    cfg_thresh = 8'd0;
    cyc(0, 1, 0);
    for (int i = 0; i < 260; i++) cyc(1, 0, 0);
    idle(2);

    req = "R5 R6 R7";                 // delay timer, tick every cycle and every third cycle
    cfg_thresh = 8'd4; cfg_delay = 8'd5;
    cyc(0, 1, 0);
    cyc(1, 0, 0);
    for (int i = 0; i < 8; i++) cyc(0, 0, 1);
    cyc(1, 0, 0);
    cyc(1, 0, 0);
    for (int i = 0; i < 20; i++) cyc(0, 0, (i % 3) == 0);

    req = "R9";                       // ticks while stopped
    for (int i = 0; i < 6; i++) cyc(0, 0, 1);

    req = "R5";                       // restart mid-run, then zero delay frame leaves timer
    cyc(1, 0, 0);
    cyc(0, 0, 1); cyc(0, 0, 1);
    cyc(1, 0, 1);
    cfg_delay = 8'd0;
    cyc(1, 0, 1); cyc(0, 0, 1);
    for (int i = 0; i < 8; i++) cyc(0, 0, 1);

    req = "R8";                       // reload collides with the last frame
    cfg_thresh = 8'd2; cfg_delay = 8'd0;
    cyc(0, 1, 0);
    cyc(1, 0, 0);
    cyc(1, 1, 0);
    cyc(1, 1, 0);
    idle(2);

    req = "R10";                      // restart on the expiry tick
    cfg_delay = 8'd2;
    cyc(1, 0, 0);
    cyc(0, 0, 1);
    cyc(1, 0, 1);
    cyc(0, 0, 1); cyc(0, 0, 1);
    req = "R7 R8";                    // expiry and decrement in one cycle
    cfg_delay = 8'd0; cfg_thresh = 8'd9;
    cyc(1, 0, 0); cfg_delay = 8'd1; cyc(1, 0, 0); cfg_delay = 8'd0; cyc(1, 0, 1);
    idle(2);

    req = "R2 R3 R5 R6 R7 R8 R9 R10";   // pseudo-random mix
    lf = 16'hACE1;
    for (int i = 0; i < 3000; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      if (lf[7:4] == 4'h0) cfg_thresh = {5'd0, lf[10:8]};
      if (lf[7:4] == 4'h1) cfg_delay  = {4'd0, lf[11:8]};
      cyc(lf[0] & lf[3], lf[14:12] == 3'd0, lf[1] | lf[2]);
    end

    req = "R1";                       // reset again mid-traffic
    rst_n = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(4);
    finish_run();
  end
endmodule